// File: doc/BRIEF.md
# Self-Test Frame Launch Controller

This block is one 32-bit control and status register, plus the sequencing logic behind it. Software uses it to start a built-in self-test frame on one of three serial storage ports. Software writes an initiate bit for a port. The block sees that the stored bit has gone from 0 to 1, checks that the port can take a frame, and raises a single launch request towards that port's link layer. The request carries a shared 6-bit parameter, which sits in the upper six bits of the pattern byte, and two 32-bit test data words.

Only one launch may be outstanding at a time. The link layer first acknowledges the request. It then reports done or fail, and the block latches that outcome into a status flag that software clears by writing 1. A port whose test succeeded stays locked against further launches until its enable input drops and returns. After a failure, software retries by clearing the initiate bit and then setting it again.

Top module: `selftest_launch_ctrl`

## Requirements
- R1: Register layout: initiate bits for port 0, port 1 and port 2 sit at bits 8, 9 and 12. The success flag is bit 11, the failure flag is bit 10, and the 6-bit parameter is bits 7:2. Bits 31:13 and 1:0 always read 0, and writes to them have no effect. All fields reset to 0.
- R2: A launch is attempted only when a write changes a stored initiate bit from 0 to 1. Writing 1 over an initiate bit that is already 1 does not launch.
- R3: A port is eligible when its present, ready and enable inputs are all 1 and its low-power input is 0. A rising edge on an ineligible port is discarded, not queued, and changes no status flag.
- R4: A launch drives `lnk_req` one-hot (bit i for port i) on the clock edge that stores the write. `lnk_req` is held until the cycle in which `lnk_ack` is high. The launch carries `lnk_pattern` = {parameter written, 2'b00}, and carries both data inputs as sampled at the launch edge.
- R5: While a launch is outstanding (from launch until done or fail), new rising edges are ignored. When one write raises several eligible ports, only the lowest-numbered port launches.
- R6: After acknowledge, `lnk_done` high sets the success flag and `lnk_fail` high sets the failure flag. Either flag is visible on the next cycle, and either one ends the outstanding launch.
- R7: Writing 1 to bit 11 or bit 10 clears that flag, and writing 0 leaves it unchanged. If a set and a clear hit the same flag in the same cycle, the set wins.
- R8: After a successful launch on a port, later rising edges on that port are ignored until the port's enable input has been 0 for at least one clock edge and has then returned to 1.
- R9: A failed launch does not lock the port. Clearing and then setting the same initiate bit launches again, with no limit on retries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| port_present | input | 3 | Device present, per port |
| port_ready | input | 3 | Device ready, per port |
| port_lowpwr | input | 3 | Port in partial/slumber low-power state, per port |
| port_enable | input | 3 | Port enable, per port |
| td_word0 | input | 32 | First test data word |
| td_word1 | input | 32 | Second test data word |
| lnk_req | output | 3 | One-hot launch request to a port's link layer |
| lnk_ack | input | 1 | Link layer has taken the request |
| lnk_done | input | 1 | Outstanding self-test frame completed |
| lnk_fail | input | 1 | Outstanding self-test frame failed |
| lnk_pattern | output | 8 | Pattern byte: parameter in bits 7:2, zeros below |
| lnk_word0 | output | 32 | First data word of the launch |
| lnk_word1 | output | 32 | Second data word of the launch |

## Verification
The assertions check the following on every cycle:
- reserved bits read as zero;
- the request stays one-hot and holds steady until acknowledged;
- a new request never appears while a launch is outstanding, on a locked port, or on an ineligible port;
- done and fail raise their flags on the next cycle.

Some behaviours only the bench's scenarios can show:
- that a launch carries the right parameter and data words;
- that discarded edges are really lost rather than deferred;
- that the lowest port wins a simultaneous write;
- that set beats clear on a flag;
- that the lock lifts only after an enable toggle, and that a retry after failure works.

// File: rtl/selftest_launch_ctrl.sv
module selftest_launch_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [2:0]    port_present,
  input  logic [2:0]    port_ready,
  input  logic [2:0]    port_lowpwr,
  input  logic [2:0]    port_enable,
  input  logic [DW-1:0] td_word0,
  input  logic [DW-1:0] td_word1,
  output logic [2:0]    lnk_req,
  input  logic          lnk_ack,
  input  logic          lnk_done,
  input  logic          lnk_fail,
  output logic [7:0]    lnk_pattern,
  output logic [DW-1:0] lnk_word0,
  output logic [DW-1:0] lnk_word1
);

  logic [2:0]    init_r, lock_r, req_r, cur_r;
  logic [5:0]    parm_r;
  logic          succ_r, fail_r, busy_r;
  logic [7:0]    pat_r;
  logic [DW-1:0] w0_r, w1_r;

  wire [2:0] wr_init = {reg_wdata[12], reg_wdata[9], reg_wdata[8]};
  wire [2:0] rise    = reg_wr_en ? (wr_init & ~init_r) : 3'b000;
  wire [2:0] able    = port_present & port_ready & ~port_lowpwr & port_enable & ~lock_r;
  wire [2:0] cand    = rise & able;
  wire [2:0] pick    = cand & (~cand + 3'd1);
  wire       launch  = ~busy_r & (|cand);
  wire       waiting = busy_r & ~(|req_r);
  wire       fin_ok  = waiting & lnk_done;
  wire       fin_bad = waiting & lnk_fail;
  wire       clr_ok  = reg_wr_en & reg_wdata[11];
  wire       clr_bad = reg_wr_en & reg_wdata[10];
  wire       unused_wbits = ^{reg_wdata[31:13], reg_wdata[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_r <= '0;
      parm_r <= '0;
      succ_r <= 1'b0;
      fail_r <= 1'b0;
      busy_r <= 1'b0;
      req_r  <= '0;
      cur_r  <= '0;
      lock_r <= '0;
      pat_r  <= '0;
      w0_r   <= '0;
      w1_r   <= '0;
    end else begin
      if (reg_wr_en) begin
        init_r <= wr_init;
        parm_r <= reg_wdata[7:2];
      end
      succ_r <= fin_ok  | (succ_r & ~clr_ok);
      fail_r <= fin_bad | (fail_r & ~clr_bad);
      if (launch) begin
        busy_r <= 1'b1;
        req_r  <= pick;
        cur_r  <= pick;
        pat_r  <= {reg_wdata[7:2], 2'b00};
        w0_r   <= td_word0;
        w1_r   <= td_word1;
      end else begin
        if ((|req_r) && lnk_ack) req_r <= '0;
        if (fin_ok || fin_bad) busy_r <= 1'b0;
      end
      for (int i = 0; i < 3; i++) begin
        if (!port_enable[i])          lock_r[i] <= 1'b0;
        else if (fin_ok && cur_r[i])  lock_r[i] <= 1'b1;
      end
    end
  end

  assign reg_rdata   = {19'd0, init_r[2], succ_r, fail_r, init_r[1], init_r[0], parm_r, 2'b00};
  assign lnk_req     = req_r;
  assign lnk_pattern = pat_r;
  assign lnk_word0   = w0_r;
  assign lnk_word1   = w1_r;

endmodule

// File: rtl/selftest_launch_chk.sv
module selftest_launch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rdata,
  input logic [2:0]  port_present,
  input logic [2:0]  port_ready,
  input logic [2:0]  port_lowpwr,
  input logic [2:0]  lnk_req,
  input logic        lnk_ack,
  input logic        lnk_done,
  input logic        lnk_fail,
  input logic [7:0]  lnk_pattern,
  input logic        busy_r,
  input logic [2:0]  lock_r
);

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:13] == 19'd0 && reg_rdata[1:0] == 2'b00);

  assert_req_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lnk_req));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|lnk_req) && !lnk_ack |=> lnk_req == $past(lnk_req));

  assert_pat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|lnk_req) |-> lnk_pattern[1:0] == 2'b00);

  assert_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|lnk_req) |-> !$past(busy_r));

  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|lnk_req) |-> (lnk_req & ~$past(port_present & port_ready & ~port_lowpwr)) == 3'b000);

  assert_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|lnk_req) |-> (lnk_req & $past(lock_r)) == 3'b000);

  assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r && lnk_req == 3'b000 && lnk_done |=> reg_rdata[11]);

  assert_fail_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r && lnk_req == 3'b000 && lnk_fail |=> reg_rdata[10]);

endmodule

bind selftest_launch_ctrl selftest_launch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata),
  .port_present(port_present), .port_ready(port_ready), .port_lowpwr(port_lowpwr),
  .lnk_req(lnk_req), .lnk_ack(lnk_ack), .lnk_done(lnk_done), .lnk_fail(lnk_fail),
  .lnk_pattern(lnk_pattern), .busy_r(busy_r), .lock_r(lock_r)
);

// File: tb/selftest_launch_ctrl_bench.sv
module selftest_launch_ctrl_bench;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr_en = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [2:0]  port_present = 0, port_ready = 0, port_lowpwr = 0, port_enable = 0;
  logic [31:0] td_word0 = 0, td_word1 = 0;
  logic [2:0]  lnk_req;
  logic        lnk_ack = 0, lnk_done = 0, lnk_fail = 0;
  logic [7:0]  lnk_pattern;
  logic [31:0] lnk_word0, lnk_word1;

  typedef struct packed {
    logic [2:0]  port;
    logic [7:0]  pat;
    logic [31:0] w0;
    logic [31:0] w1;
  } launch_t;

  launch_t exp_q[$];
  int      n_chk = 0, n_bad = 0;
  bit      done_flag = 0;
  logic [2:0] prev_req = 0;

  always #4 clk = ~clk;

  selftest_launch_ctrl u_selftest_launch_ctrl (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] ini, input logic [5:0] p, input logic [1:0] w1c);
    return {19'd0, ini[2], w1c[1], w1c[0], ini[1], ini[0], p, 2'b00};
  endfunction

  task automatic do_write(input logic [31:0] v);
    @(negedge clk); reg_wr_en = 1; reg_wdata = v;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic push_launch(input logic [2:0] port, input logic [5:0] p);
    exp_q.push_back('{port: port, pat: {p, 2'b00}, w0: td_word0, w1: td_word1});
  endtask

  task automatic pulse_ack;
    @(negedge clk); lnk_ack = 1;
    @(negedge clk); lnk_ack = 0;
  endtask

  task automatic pulse_done;
    @(negedge clk); lnk_done = 1;
    @(negedge clk); lnk_done = 0;
  endtask

  task automatic pulse_fail;
    @(negedge clk); lnk_fail = 1;
    @(negedge clk); lnk_fail = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: every new request is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (lnk_req != 3'b000 && prev_req == 3'b000) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected launch request", {29'd0, lnk_req}, 32'd0);
        end else begin
          launch_t e;
          e = exp_q.pop_front();
          check("R4 launch port", {29'd0, lnk_req}, {29'd0, e.port});
          check("R4 launch pattern", {24'd0, lnk_pattern}, {24'd0, e.pat});
          check("R4 launch word0", lnk_word0, e.w0);
          check("R4 launch word1", lnk_word1, e.w1);
        end
      end
      prev_req = lnk_req;
    end
  end

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    check("R1 reset rdata", reg_rdata, 32'd0);
    check("R1 reset req", {29'd0, lnk_req}, 32'd0);

    // R1 layout, R3 absent ports discard edges
    do_write(32'hFFFF_F3FF);
    check("R1 reserved read zero", reg_rdata, 32'h0000_13FC);
    idle(2);
    check("R3 absent port no launch", {29'd0, lnk_req}, 32'd0);
    do_write(32'd0);
    check("R1 write zero", reg_rdata, 32'd0);

    port_present = 3'b111; port_ready = 3'b111; port_enable = 3'b111; port_lowpwr = 3'b000;
    td_word0 = 32'hA5A5_0001; td_word1 = 32'h5A5A_1000;
    push_launch(3'b001, 6'h2A);
    do_write(mk(3'b001, 6'h2A, 2'b00));
    idle(3);
    check("R4 request held until ack", {29'd0, lnk_req}, 32'd1);
    pulse_ack();
    check("R4 request drops after ack", {29'd0, lnk_req}, 32'd0);
    do_write(mk(3'b011, 6'h2A, 2'b00));
    idle(1);
    check("R5 edge while busy ignored", {29'd0, lnk_req}, 32'd0);
    pulse_done();
    check("R6 success flag", {31'd0, reg_rdata[11]}, 32'd1);
    check("R6 fail flag clear", {31'd0, reg_rdata[10]}, 32'd0);

    // R7 write-1-to-clear
    do_write(mk(3'b011, 6'h2A, 2'b10));
    check("R7 w1c success", reg_rdata, mk(3'b011, 6'h2A, 2'b00));

    // R8 lock after success
    do_write(mk(3'b010, 6'h2A, 2'b00));
    do_write(mk(3'b011, 6'h2A, 2'b00));
    idle(1);
    check("R8 locked port ignored", {29'd0, lnk_req}, 32'd0);
    @(negedge clk); port_enable[0] = 0;
    @(negedge clk); port_enable[0] = 1;
    do_write(mk(3'b010, 6'h15, 2'b00));
    td_word0 = 32'h1234_5678; td_word1 = 32'h9ABC_DEF0;
    push_launch(3'b001, 6'h15);
    do_write(mk(3'b011, 6'h15, 2'b00));
    check("R8 launch after enable toggle", {29'd0, lnk_req}, 32'd1);
    pulse_ack();
    pulse_fail();
    check("R6 fail flag set", {31'd0, reg_rdata[10]}, 32'd1);

    // R9 retry after failure
    do_write(mk(3'b010, 6'h15, 2'b01));
    check("R7 w1c fail", {31'd0, reg_rdata[10]}, 32'd0);
    td_word0 = 32'h0000_FFFF;
    push_launch(3'b001, 6'h15);
    do_write(mk(3'b011, 6'h15, 2'b00));
    check("R9 retry launches", {29'd0, lnk_req}, 32'd1);
    pulse_ack();
    // R7 set beats clear in the same cycle
    @(negedge clk); lnk_done = 1; reg_wr_en = 1; reg_wdata = mk(3'b011, 6'h15, 2'b10);
    @(negedge clk); lnk_done = 0; reg_wr_en = 0;
    check("R7 set wins over clear", {31'd0, reg_rdata[11]}, 32'd1);
    do_write(mk(3'b011, 6'h15, 2'b10));
    check("R7 clear afterwards", {31'd0, reg_rdata[11]}, 32'd0);

    // R3 gating on port 2
    port_lowpwr[2] = 1;
    do_write(mk(3'b111, 6'h15, 2'b00));
    idle(1);
    check("R3 low-power port ignored", {29'd0, lnk_req}, 32'd0);
    check("R3 no flag change", {30'd0, reg_rdata[11:10]}, 32'd0);
    port_lowpwr[2] = 0;
    do_write(mk(3'b011, 6'h15, 2'b00));
    port_ready[2] = 0;
    do_write(mk(3'b111, 6'h15, 2'b00));
    idle(1);
    check("R3 not-ready port ignored", {29'd0, lnk_req}, 32'd0);
    port_ready[2] = 1;
    idle(2);
    check("R3 discarded edge not queued", {29'd0, lnk_req}, 32'd0);
    do_write(mk(3'b011, 6'h15, 2'b00));
    port_present[2] = 0;
    do_write(mk(3'b111, 6'h15, 2'b00));
    idle(1);
    check("R3 absent port 2 ignored", {29'd0, lnk_req}, 32'd0);
    port_present[2] = 1;
    do_write(mk(3'b011, 6'h15, 2'b00));
    td_word1 = 32'hCAFE_0002;
    push_launch(3'b100, 6'h3F);
    do_write(mk(3'b111, 6'h3F, 2'b00));
    check("R4 port 2 request", {29'd0, lnk_req}, 32'd4);
    pulse_ack();
    pulse_done();
    check("R6 port 2 success", {31'd0, reg_rdata[11]}, 32'd1);
    do_write(mk(3'b111, 6'h3F, 2'b10));

    // R5 simultaneous edges: lowest port wins
    do_write(mk(3'b000, 6'h3F, 2'b00));
    @(negedge clk); port_enable[0] = 0;
    @(negedge clk); port_enable[0] = 1;
    td_word0 = 32'h0BAD_F00D;
    push_launch(3'b001, 6'h07);
    do_write(mk(3'b011, 6'h07, 2'b00));
    check("R5 lowest port picked", {29'd0, lnk_req}, 32'd1);
    pulse_ack();
    pulse_fail();
    idle(2);
    check("R5 second port discarded", {29'd0, lnk_req}, 32'd0);
    check("R6 fail after simultaneous", {31'd0, reg_rdata[10]}, 32'd1);

    // R2 writing 1 over 1 does not launch
    do_write(mk(3'b011, 6'h07, 2'b01));
    idle(2);
    check("R2 no launch on held bit", {29'd0, lnk_req}, 32'd0);
    check("R2 register readback", reg_rdata, mk(3'b011, 6'h07, 2'b00));

    idle(3);
    check("R4 scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule